// File: doc/BRIEF.md
# Seconds Counter with Alarm

A timekeeping peripheral on a simple 32-bit register bus. A prescaler divides the system clock into a one-per-second tick. Each tick advances a 32-bit seconds count, which wraps modulo 2^32. Software can load the count, program an alarm value and mask or acknowledge one level-sensitive alarm interrupt. Fixed identification bytes sit in the top words of a 4 KB register window.

Writes take effect on the rising clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr`. Only word-aligned addresses are decoded. The alarm status is a two-state machine. In `ALM_ARMED` no alarm is pending. The transition `ARM_TO_FIRE` moves it to `ALM_FIRED` when a hit occurs. A hit means that the count, as it will be after this edge, equals the alarm value, as it will be after this edge, and that this edge carries a tick, a count load or an alarm write. The transition `FIRE_TO_ARM` returns it to `ALM_ARMED` when software acknowledges with bit 0 set and no hit occurs in that same cycle.

Top module: `rtc_sec_alarm`

Register words (byte address): 0x00 live count (read only), 0x04 alarm value, 0x08 load, 0x0C control, 0x10 mask, 0x14 raw status, 0x18 masked status, 0x1C acknowledge (write only).

## Requirements
- R1: After reset the count, alarm value, load register, mask and raw status all read zero, and `irq` is low.
- R2: The count rises by exactly 1 once every `TICKS_PER_SEC` clocks and holds between ticks.
- R3: The count wraps from 0xFFFFFFFF to 0. An alarm value of 0 fires on that wrap.
- R4: A write to 0x08 sets the count to the written value, and 0x08 reads back that value. The load restarts the prescaler, so the next increment comes `TICKS_PER_SEC` clocks after the load edge.
- R5: When a tick makes the count equal to the alarm value, raw status (0x14 bit 0) becomes 1 on that edge. It stays 1 until software acknowledges it.
- R6: Writing an alarm value equal to the current count sets raw status at once. Loading a count equal to the alarm value also sets it at once.
- R7: The mask (0x10) stores only bit 0. Masked status (0x18) equals raw AND mask, and `irq` follows masked status.
- R8: A write to 0x1C with bit 0 set clears raw status. With bit 0 clear, the write has no effect. 0x1C always reads 0.
- R9: If an acknowledge and a hit fall in the same cycle, the hit wins and raw status stays 1.
- R10: Control (0x0C) always reads 1, and writes to it change nothing.
- R11: Addresses 0xFE0, 0xFE4 … 0xFFC read one byte each, in this order: 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Writes to 0x00, 0x14 and 0x18 are ignored. Unmapped or misaligned addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Masked alarm interrupt, level |

## Verification
The two functions that can collide are the software acknowledge and a tick that reaches the alarm value. The bench loads a count one below the alarm value. It then counts clocks from that load so that the acknowledge write lands on exactly the edge that carries the prescaler tick. The result is judged by reading raw status: it must still be 1, and the count must show the new second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam int unsigned ID_N   = 8;
    localparam int unsigned ID_IW  = $clog2(ID_N);

    localparam logic [WORD_W-1:0] W_COUNT = 10'h000;
    localparam logic [WORD_W-1:0] W_MATCH = 10'h001;
    localparam logic [WORD_W-1:0] W_LOAD  = 10'h002;
    localparam logic [WORD_W-1:0] W_CTRL  = 10'h003;
    localparam logic [WORD_W-1:0] W_MASK  = 10'h004;
    localparam logic [WORD_W-1:0] W_RAW   = 10'h005;
    localparam logic [WORD_W-1:0] W_MSKD  = 10'h006;
    localparam logic [WORD_W-1:0] W_ACK   = 10'h007;
    localparam logic [ADDR_W-ID_IW-3:0] ID_PAGE = '1;

    typedef enum logic {
        ALM_ARMED = 1'b0,
        ALM_FIRED = 1'b1
    } alm_state_t;

    function automatic logic [7:0] id_byte(input logic [ID_IW-1:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0: b = 8'h31;
            3'd1: b = 8'h10;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned PH_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_SEC - 1);

    logic [PH_W-1:0] phase_q;

    assign tick = (phase_q == PH_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] count_next
);
    always_comb begin
        if (load_en) begin
            count_next = load_val;
        end else if (tick) begin
            count_next = count + 1'b1;
        end else begin
            count_next = count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count_next;
        end
    end
endmodule

// File: rtl/rtc_alarm_fsm.sv
module rtc_alarm_fsm
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval,
    input  logic [DATA_W-1:0] count_next,
    input  logic              match_wr,
    input  logic [DATA_W-1:0] match_val,
    input  logic              mask_wr,
    input  logic              mask_val,
    input  logic              ack,
    output logic [DATA_W-1:0] match_q,
    output logic              mask_q,
    output logic              raw,
    output logic              irq
);
    alm_state_t        state_q, state_d;
    logic [DATA_W-1:0] match_next;
    logic              hit;

    assign match_next = match_wr ? match_val : match_q;
    assign hit        = eval && (count_next == match_next);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= '0;
            mask_q  <= 1'b0;
        end else begin
            match_q <= match_next;
            if (mask_wr) begin
                mask_q <= mask_val;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ALM_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: ARM_TO_FIRE on hit, FIRE_TO_ARM on ack without hit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_ARMED: if (hit)         state_d = ALM_FIRED;
            ALM_FIRED: if (ack && !hit) state_d = ALM_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        raw = (state_q == ALM_FIRED);
        irq = raw && mask_q;
    end
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
    import rtc_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              aligned, id_area, wr_en;
    logic [WORD_W-1:0] word;
    logic              load_wr, match_wr, mask_wr, ack_wr;
    logic              sec_tick;
    logic [DATA_W-1:0] cnt_q, cnt_next, match_q, load_q;
    logic              alm_raw, alm_mask;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign word     = bus_addr[ADDR_W-1:2];
    assign id_area  = (bus_addr[ADDR_W-1:ID_IW+2] == ID_PAGE);
    assign wr_en    = bus_sel && bus_wr && aligned;
    assign load_wr  = wr_en && (word == W_LOAD);
    assign match_wr = wr_en && (word == W_MATCH);
    assign mask_wr  = wr_en && (word == W_MASK);
    assign ack_wr   = wr_en && (word == W_ACK) && bus_wdata[0];

    rtc_tick_gen #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_wr),
        .tick    (sec_tick)
    );

    rtc_seconds u_sec (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (sec_tick),
        .load_en    (load_wr),
        .load_val   (bus_wdata),
        .count      (cnt_q),
        .count_next (cnt_next)
    );

    rtc_alarm_fsm u_alm (
        .clk        (clk),
        .rst_n      (rst_n),
        .eval       (sec_tick || load_wr || match_wr),
        .count_next (cnt_next),
        .match_wr   (match_wr),
        .match_val  (bus_wdata),
        .mask_wr    (mask_wr),
        .mask_val   (bus_wdata[0]),
        .ack        (ack_wr),
        .match_q    (match_q),
        .mask_q     (alm_mask),
        .raw        (alm_raw),
        .irq        (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (load_wr) begin
            load_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (id_area) begin
                bus_rdata = DATA_W'(id_byte(bus_addr[ID_IW+1:2]));
            end else begin
                case (word)
                    W_COUNT: bus_rdata = cnt_q;
                    W_MATCH: bus_rdata = match_q;
                    W_LOAD:  bus_rdata = load_q;
                    W_CTRL:  bus_rdata = DATA_W'(1);
                    W_MASK:  bus_rdata = DATA_W'(alm_mask);
                    W_RAW:   bus_rdata = DATA_W'(alm_raw);
                    W_MSKD:  bus_rdata = DATA_W'(alm_raw && alm_mask);
                    default: bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic [DATA_W-1:0] count,
    input logic              raw,
    input logic              mask,
    input logic              tick
);
    logic wr, ld;
    assign wr = bus_sel && bus_wr;
    assign ld = wr && (bus_addr == 12'h008);

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!irq && !raw); // R1
        end
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (count == $past(bus_wdata))); // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld) |=> (count == $past(count) + 32'd1)); // R2
    AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld) |=> $stable(count)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && count == 32'hFFFF_FFFF) |=> (count == 32'd0)); // R3
    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !(wr && bus_addr == 12'h01C && bus_wdata[0])) |=> raw); // R5
    AST_MATCH_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 12'h004 && !tick && bus_wdata == count) |=> raw); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw && mask)); // R7
    AST_IRQ_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && mask) |-> irq); // R7
    AST_MASK_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 12'h010) |=> (mask == $past(bus_wdata[0]))); // R7
    AST_ACK_READ0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 12'h01C) |-> (bus_rdata == 32'd0)); // R8
    AST_CTRL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 12'h00C) |-> (bus_rdata == 32'd1)); // R10
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .count     (cnt_q),
    .raw       (alm_raw),
    .mask      (alm_mask),
    .tick      (sec_tick)
);

// File: tb/rtc_sec_alarm_test.sv
module rtc_sec_alarm_test;
    localparam int T = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_sec_alarm #(.TICKS_PER_SEC(T)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge, returns at the negedge after
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] e);
        logic [31:0] v;
        rd(a, v);
        check(req, v, e);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic t_reset;
        expect_rd("R1 count", 12'h000, 32'd0);
        expect_rd("R1 match", 12'h004, 32'd0);
        expect_rd("R1 load", 12'h008, 32'd0);
        expect_rd("R1 mask", 12'h010, 32'd0);
        expect_rd("R1 raw", 12'h014, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_prescale;
        wr(12'h008, 32'd1000);
        expect_rd("R4 load sets count", 12'h000, 32'd1000);
        expect_rd("R4 load readback", 12'h008, 32'd1000);
        step(T - 1);
        expect_rd("R4 phase restart, no tick yet", 12'h000, 32'd1000);
        step(1);
        expect_rd("R2 first tick", 12'h000, 32'd1001);
        step(T);
        expect_rd("R2 second tick", 12'h000, 32'd1002);
    endtask

    task automatic t_wrap;
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h004, 32'd0);
        wr(12'h01C, 32'd1);
        expect_rd("R3 no alarm before wrap", 12'h014, 32'd0);
        step(T - 2);
        expect_rd("R3 count wrapped", 12'h000, 32'd0);
        expect_rd("R3 alarm at wrap", 12'h014, 32'd1);
    endtask

    task automatic t_tick_match;
        wr(12'h008, 32'd100);
        wr(12'h004, 32'd102);
        wr(12'h01C, 32'd1);
        step(T - 2);
        expect_rd("R5 count 101", 12'h000, 32'd101);
        expect_rd("R5 not yet", 12'h014, 32'd0);
        step(T);
        expect_rd("R5 count 102", 12'h000, 32'd102);
        expect_rd("R5 raw set on match", 12'h014, 32'd1);
        step(T);
        expect_rd("R5 raw sticky", 12'h014, 32'd1);
    endtask

    task automatic t_immediate;
        wr(12'h008, 32'd500);
        wr(12'h01C, 32'd1);
        expect_rd("R6 cleared first", 12'h014, 32'd0);
        wr(12'h004, 32'd500);
        expect_rd("R6 match write equal", 12'h014, 32'd1);
        wr(12'h004, 32'd777);
        wr(12'h01C, 32'd1);
        expect_rd("R6 cleared again", 12'h014, 32'd0);
        wr(12'h008, 32'd777);
        expect_rd("R6 load equal", 12'h014, 32'd1);
    endtask

    task automatic t_mask_ack;
        wr(12'h010, 32'hFFFF_FFFF);
        expect_rd("R7 mask keeps bit0", 12'h010, 32'd1);
        expect_rd("R7 masked status", 12'h018, 32'd1);
        check("R7 irq high", {31'd0, irq}, 32'd1);
        wr(12'h010, 32'hFFFF_FFFE);
        expect_rd("R7 masked off", 12'h018, 32'd0);
        check("R7 irq low", {31'd0, irq}, 32'd0);
        expect_rd("R7 raw unaffected", 12'h014, 32'd1);
        wr(12'h01C, 32'hFFFF_FFFE);
        expect_rd("R8 ack bit0=0 ignored", 12'h014, 32'd1);
        expect_rd("R8 ack reads 0", 12'h01C, 32'd0);
        wr(12'h01C, 32'd1);
        expect_rd("R8 ack clears", 12'h014, 32'd0);
    endtask

    task automatic t_collide;
        wr(12'h008, 32'd40);
        wr(12'h004, 32'd41);
        wr(12'h01C, 32'd1);
        step(T - 3);
        wr(12'h01C, 32'd1);   // lands on the tick edge
        expect_rd("R9 count advanced", 12'h000, 32'd41);
        expect_rd("R9 hit beats ack", 12'h014, 32'd1);
    endtask

    task automatic t_ctrl_id;
        expect_rd("R10 ctrl reads 1", 12'h00C, 32'd1);
        wr(12'h00C, 32'd0);
        expect_rd("R10 ctrl write ignored", 12'h00C, 32'd1);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] e;
            case (i)
                0: e = 8'h31; 1: e = 8'h10; 2: e = 8'h14; 3: e = 8'h00;
                4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
            endcase
            expect_rd("R11 id byte", 12'hFE0 + 12'(i * 4), {24'd0, e});
        end
    endtask

    task automatic t_ignored;
        wr(12'h004, 32'd9);
        wr(12'h008, 32'd1234);
        wr(12'h01C, 32'd1);
        wr(12'h000, 32'd5);
        expect_rd("R12 count write ignored", 12'h000, 32'd1234);
        wr(12'h014, 32'd1);
        expect_rd("R12 raw write ignored", 12'h014, 32'd0);
        wr(12'h018, 32'd1);
        expect_rd("R12 masked write ignored", 12'h014, 32'd0);
        expect_rd("R12 unmapped 0x020", 12'h020, 32'd0);
        expect_rd("R12 unmapped 0x800", 12'h800, 32'd0);
        expect_rd("R12 misaligned", 12'h00D, 32'd0);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_prescale();
        t_wrap();
        t_tick_match();
        t_immediate();
        t_mask_ack();
        t_collide();
        t_ctrl_id();
        t_ignored();
        finish_run();
    end
endmodule